// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a small on-chip synchronous memory whose timing allows a read or a write to start on every clock. The data bus never needs an idle cycle when the traffic switches between reads and writes. The address, the read/write select and the per-lane write enables are all sampled on the edge that starts a cycle. Write data is taken two edges later. Read data is registered and appears on that same later edge. Because reads and writes occupy the same pipeline slot, any mix of operations can be issued back to back.

The data word is split into byte lanes, by default two lanes of nine bits; a ninth bit is stored as ordinary data. A cycle is started with the load strobe low. While the strobe is high, the block keeps the last cycle type and steps the low two address bits through a four-access linear burst that wraps around. Three select inputs must all be at their active levels for a load to address the array; any other combination turns the load into a deselect bubble. A clock enable freezes every pipeline stage.

Top module: `zbt_sram`

## Requirements
- R1: A write loaded at edge N with byte-lane enables sampled at edge N stores the word present on `wdata` at edge N+2, and a later read of that address returns it.
- R2: Lane i (bits i*LANE_W up to i*LANE_W+LANE_W-1) is written only when `lane_we_n[i]` was low at the loading edge. Lanes whose enable was high keep their old contents.
- R3: For a read loaded at edge N, `rdata` holds the addressed word after edge N+2. With `oe_n` low, `rdata_drv` is 1 for that interval.
- R4: `rdata_drv` is 0 whenever `oe_n` is high, and it follows `oe_n` without waiting for a clock.
- R5: A load is a deselect unless `chip_sel_n` is low, `exp_sel` is high and `exp_sel_n` is low. A deselect writes nothing and leaves `rdata_drv` at 0 in its output slot, and advances that follow it remain deselects.
- R6: An edge with `load_n` high repeats the previous cycle type at the next burst address. The address is formed by adding 1 modulo 4 to the low two bits and keeping the upper bits unchanged.
- R7: The fifth access of a burst (the fourth advance) returns to the base address of the burst.
- R8: An edge with `clk_en` low changes no pipeline stage, no stored word, `rdata` or `rdata_drv`. All other inputs are ignored on that edge.
- R9: Operations issued on every clock, alternating between writing and reading the same address, each return the value written just before them.
- R10: After reset, `rdata_drv` is 0 and the pipeline holds only deselects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling is on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline control |
| clk_en | input | 1 | High lets the pipeline advance on an edge |
| chip_sel_n | input | 1 | Primary select, active low |
| exp_sel | input | 1 | Depth-expansion select, active high |
| exp_sel_n | input | 1 | Depth-expansion select, active low |
| load_n | input | 1 | Low loads a new cycle, high advances the burst |
| wr_n | input | 1 | Low selects write, high selects read (used on a load) |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address sampled on a load |
| wdata | input | LANES*LANE_W | Write data, taken two edges after its address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_drv | output | 1 | High when `rdata` should drive the bus |

## Verification
The assertions assume that `rst_n` is held low for at least two edges with `clk_en` high, so that both pipeline stages start as deselects. They also assume the address is wide enough for a four-word burst. The stimulus always holds reset that long. It changes inputs only at the falling edge, and it toggles `oe_n` only on edges where `clk_en` is low, so the output-enable checks never overlap an update of the pipeline. Every read the stimulus issues targets a word that was written earlier in full.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              chip_sel_n,
  input  logic              exp_sel,
  input  logic              exp_sel_n,
  input  logic              load_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_drv
);

  localparam logic [1:0] K_DES = 2'd0;
  localparam logic [1:0] K_RD  = 2'd1;
  localparam logic [1:0] K_WR  = 2'd2;

  logic [1:0]        stg1_kind, stg2_kind, kind_nxt;
  logic [ADDR_W-1:0] stg1_addr, stg2_addr, addr_nxt;
  logic [LANES-1:0]  stg1_mask, stg2_mask;
  logic              rd_valid;
  logic              selected;
  logic              exec_wr, exec_rd;

  assign selected = !chip_sel_n && exp_sel && !exp_sel_n;
  assign kind_nxt = load_n ? stg1_kind : (!selected ? K_DES : (wr_n ? K_RD : K_WR));
  assign addr_nxt = load_n ? {stg1_addr[ADDR_W-1:2], stg1_addr[1:0] + 2'd1} : addr;

  assign exec_wr = rst_n && clk_en && (stg2_kind == K_WR);
  assign exec_rd = rst_n && clk_en && (stg2_kind == K_RD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg1_kind <= K_DES;
      stg2_kind <= K_DES;
      stg1_addr <= '0;
      stg2_addr <= '0;
      stg1_mask <= '0;
      stg2_mask <= '0;
      rd_valid  <= 1'b0;
    end else if (clk_en) begin
      stg1_kind <= kind_nxt;
      stg1_addr <= addr_nxt;
      stg1_mask <= ~lane_we_n;
      stg2_kind <= stg1_kind;
      stg2_addr <= stg1_addr;
      stg2_mask <= stg1_mask;
      rd_valid  <= (stg2_kind == K_RD);
    end
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (exec_wr && stg2_mask[ln])
        cells[stg2_addr] <= wdata[ln*LANE_W +: LANE_W];
      if (exec_rd)
        q <= cells[stg2_addr];
    end

    assign rdata[ln*LANE_W +: LANE_W] = q;
  end

  assign rdata_drv = rd_valid && !oe_n;

endmodule

module zbt_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              load_n,
  input logic              chip_sel_n,
  input logic              exp_sel,
  input logic              exp_sel_n,
  input logic [1:0]        k1,
  input logic [1:0]        k2,
  input logic [ADDR_W-1:0] a1,
  input logic              rvalid,
  input logic [DATA_W-1:0] rdata
);

  a_r1_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> k2 == $past(k1));

  a_r3_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> rvalid == ($past(k2) == 2'd1));

  a_r5_deselect_load: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !load_n && !(!chip_sel_n && exp_sel && !exp_sel_n)) |=> k1 == 2'd0);

  a_r6_advance_keeps_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && load_n) |=> k1 == $past(k1));

  a_r7_advance_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && load_n) |=> (a1[1:0] == $past(a1[1:0]) + 2'd1) &&
                           (a1[ADDR_W-1:2] == $past(a1[ADDR_W-1:2])));

  a_r8_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(rdata) && $stable(rvalid) && $stable(k1) && $stable(k2));

endmodule

bind zbt_sram zbt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .load_n(load_n),
  .chip_sel_n(chip_sel_n), .exp_sel(exp_sel), .exp_sel_n(exp_sel_n),
  .k1(stg1_kind), .k2(stg2_kind), .a1(stg1_addr), .rvalid(rd_valid),
  .rdata(rdata)
);

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam logic [1:0] DES = 2'd0, RD = 2'd1, WR = 2'd2;

  logic clk = 0, rst_n = 0, clk_en = 1;
  logic chip_sel_n = 1, exp_sel = 0, exp_sel_n = 1;
  logic load_n = 0, wr_n = 1, oe_n = 0;
  logic [LN-1:0] lane_we_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_drv;

  zbt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .chip_sel_n(chip_sel_n),
    .exp_sel(exp_sel), .exp_sel_n(exp_sel_n), .load_n(load_n), .wr_n(wr_n),
    .lane_we_n(lane_we_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rdata_drv(rdata_drv));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic rd; logic [DW-1:0] d; string req; } item_t;
  typedef struct { logic [1:0] k; logic [AW-1:0] a; logic [LN-1:0] m; logic [DW-1:0] d; string req; } op_t;

  item_t sb[$];
  item_t last_it;
  op_t pend0, pend1;
  logic [1:0] cur_k;
  logic [AW-1:0] cur_a;
  logic [DW-1:0] model [1<<AW];
  int checks = 0, failures = 0;
  bit done = 0;

  task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(rdata_drv == it.rd, it.req, "drive", DW'(rdata_drv), DW'(it.rd));
      if (it.rd) check(rdata == it.d, it.req, "rdata", rdata, it.d);
    end
  end

  task automatic step(bit ld, bit wr, int selc, logic [LN-1:0] m,
                      logic [AW-1:0] a, logic [DW-1:0] d, string req);
    op_t o;
    item_t it;
    @(negedge clk);
    clk_en = 1;
    load_n = !ld;
    wr_n = !wr;
    chip_sel_n = (selc == 1);
    exp_sel = (selc != 2);
    exp_sel_n = (selc == 3);
    lane_we_n = ~m;
    addr = a;
    wdata = pend1.d;
    if (ld) begin
      o.k = (selc != 0) ? DES : (wr ? WR : RD);
      o.a = a;
    end else begin
      o.k = cur_k;
      o.a = {cur_a[AW-1:2], cur_a[1:0] + 2'd1};
    end
    o.m = m; o.d = d; o.req = req;
    cur_k = o.k; cur_a = o.a;
    @(posedge clk);
    if (pend1.k == WR)
      for (int l = 0; l < LN; l++)
        if (pend1.m[l]) model[pend1.a][l*LW +: LW] = pend1.d[l*LW +: LW];
    it.rd = (pend1.k == RD);
    it.d = model[pend1.a];
    it.req = pend1.req;
    sb.push_back(it);
    last_it = it;
    pend1 = pend0;
    pend0 = o;
  endtask

  task automatic hold(string req);
    item_t it;
    @(negedge clk);
    clk_en = 0;
    load_n = 0; wr_n = 0; chip_sel_n = 0; exp_sel = 1; exp_sel_n = 0;
    lane_we_n = '0; addr = 6'h2a; wdata = '1;
    @(posedge clk);
    it = last_it;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic flush();
    repeat (3) step(1, 0, 1, '0, '0, '0, "R5");
  endtask

  function automatic logic [DW-1:0] pat(int i);
    return DW'(32'h1b5a3 * (i + 7) ^ (i << 4));
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    pend0.k = DES; pend0.a = '0; pend0.m = '0; pend0.d = '0; pend0.req = "R10";
    pend1 = pend0;
    cur_k = DES; cur_a = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check(rdata_drv == 0, "R10", "drive after reset", DW'(rdata_drv), '0);

    // R1 full-word writes then reads (R3)
    for (int i = 0; i < 8; i++) step(1, 1, 0, '1, AW'(i), pat(i), "R1");
    for (int i = 0; i < 8; i++) step(1, 0, 0, '0, AW'(i), '0, "R3");
    flush();

    // R9 alternating write/read to same address every clock
    for (int i = 0; i < 6; i++) begin
      step(1, 1, 0, '1, AW'(40 + i), pat(100 + i), "R9");
      step(1, 0, 0, '0, AW'(40 + i), '0, "R9");
    end
    flush();

    // R2 partial lane writes
    step(1, 1, 0, 2'b01, 6'd3, {LW'(9'h155), LW'(9'h0aa)}, "R2");
    step(1, 1, 0, 2'b10, 6'd4, {LW'(9'h1ff), LW'(9'h000)}, "R2");
    step(1, 0, 0, '0, 6'd3, '0, "R2");
    step(1, 0, 0, '0, 6'd4, '0, "R2");
    flush();

    // R5 deselect by each select input
    step(1, 1, 0, '1, 6'd10, pat(10), "R5");
    step(1, 1, 1, '1, 6'd10, pat(11), "R5");
    step(1, 1, 2, '1, 6'd10, pat(12), "R5");
    step(1, 1, 3, '1, 6'd10, pat(13), "R5");
    step(1, 0, 0, '0, 6'd10, '0, "R5");
    flush();

    // R6/R7 burst write from base 5, fifth access wraps to 5
    step(1, 1, 0, '1, 6'd5, pat(20), "R6");
    step(0, 0, 0, '1, 6'd0, pat(21), "R6");
    step(0, 0, 0, '1, 6'd0, pat(22), "R6");
    step(0, 0, 0, '1, 6'd0, pat(23), "R6");
    step(0, 0, 0, '1, 6'd0, pat(24), "R7");
    // burst read from base 4 with clock-enable holds (R8)
    step(1, 0, 0, '0, 6'd4, '0, "R6");
    hold("R8");
    step(0, 1, 0, '0, 6'd0, '0, "R6");
    hold("R8");
    hold("R8");
    step(0, 1, 0, '0, 6'd0, '0, "R6");
    step(0, 1, 0, '0, 6'd0, '0, "R6");
    step(0, 1, 0, '0, 6'd0, '0, "R7");
    hold("R8");
    flush();
    hold("R8");

    // R5 deselect persists through advances
    step(1, 1, 0, '1, 6'd20, pat(30), "R5");
    step(1, 1, 0, '1, 6'd21, pat(31), "R5");
    step(1, 1, 2, '1, 6'd20, pat(32), "R5");
    step(0, 1, 0, '1, 6'd0, pat(33), "R5");
    step(1, 0, 0, '0, 6'd20, '0, "R5");
    step(1, 0, 0, '0, 6'd21, '0, "R5");
    flush();

    // R4 output enable acts without a clock
    step(1, 0, 0, '0, 6'd2, '0, "R3");
    step(1, 0, 1, '0, 6'd0, '0, "R5");
    step(1, 0, 1, '0, 6'd0, '0, "R5");
    @(negedge clk);
    clk_en = 0;
    #2 oe_n = 1;
    #1 check(rdata_drv == 0, "R4", "drive with oe_n high", DW'(rdata_drv), '0);
    oe_n = 0;
    #1 check(rdata_drv == 1, "R4", "drive with oe_n low", DW'(rdata_drv), DW'(1));
    flush();
    @(negedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R3", "scoreboard drained", DW'(sb.size()), '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule